// File: doc/BRIEF.md
# Excessive Deferral Watchdog

This block tracks how long a half-duplex transmitter has been held off by a busy medium before it may start a frame. While a transmit request is pending and carrier is present, it counts bit-time strobes. If the count reaches the active limit, it ends the attempt with a one-cycle abort pulse. The limit is 24,288 bit times for normal operation and 155,680 bit times at gigabit speed or with jumbo frames enabled. The abort is raised only when the deferral check is enabled and the link is half-duplex.

The block also keeps a 3-bit transmit status field. Bit 0 records that the frame had to defer. Bit 2 records that the attempt was aborted for excessive deferral. Both bits stay set until the status-clear strobe, which the MAC issues once the status has been written back.

Control is a five-state machine:
- `WD_IDLE`: no request. A rising request goes to `WD_DEFER` and clears the counter.
- `WD_DEFER`: a request is pending.
  - Carrier dropping goes to `WD_CLEAR`.
  - Reaching the limit with the check enabled in half-duplex goes to `WD_ABORT`.
- `WD_CLEAR`: the medium became free and the count is frozen.
- `WD_ABORT`: lasts exactly one cycle, then goes to `WD_HOLD`.
- `WD_HOLD`: waits with the count frozen.

From every state except `WD_IDLE`, withdrawing the request returns to `WD_IDLE`.

Top module: `defer_watchdog`

## Requirements
- R1: After reset, `st_field` is 0, and `xdef_abort` and `defer_flag` are low.
- R2: The deferral count advances by one per `bit_tick` only while `tx_req` is high and `carrier` is high in the deferring state. It holds without a strobe and restarts from zero when a new request begins.
- R3: With `fast_mode` low, `xdef_abort` pulses for exactly one cycle when the count reaches `NORM_LIMIT` (default 24,288). The pulse appears in the cycle after the clock edge that registered the last counting strobe.
- R4: With `fast_mode` high (gigabit or jumbo), the limit is `LONG_LIMIT` (default 155,680) bit times instead.
- R5: With `defer_chk_en` low, no abort occurs and deferral continues. Bit 0 is still reported.
- R6: With `half_duplex` low, `defer_flag`, `st_field` and `xdef_abort` all stay 0.
- R7: Once carrier drops during a request, counting stops. No abort follows for that request, even if carrier returns.
- R8: After an abort, no further abort occurs while the request stays high. Withdrawing the request before the limit cancels the attempt.
- R9: `st_field[0]` is the deferred bit, `st_field[2]` is the excessive-deferral bit and `st_field[1]` reads 0. Set bits stay latched until `stat_clr`.
- R10: `stat_clr` clears `st_field` at the next edge. A set event at the same edge wins over the clear.
- R11: `defer_flag` is high in any cycle where the request is deferring to carrier in half-duplex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| carrier | input | 1 | Carrier sense |
| tx_req | input | 1 | Transmit request pending |
| fast_mode | input | 1 | Selects the long limit (gigabit or jumbo) |
| defer_chk_en | input | 1 | Enables the excessive-deferral abort |
| half_duplex | input | 1 | High in half-duplex mode |
| stat_clr | input | 1 | Clears the latched status bits |
| defer_flag | output | 1 | Currently deferring to carrier |
| xdef_abort | output | 1 | One-cycle excessive-deferral abort |
| st_field | output | 3 | Status: bit 0 deferred, bit 2 excessive deferral |

## Verification
The status clear can meet a new status event at the same edge in two ways: a clear during an ongoing deferral, and a clear at the very edge that enters the abort state. The bench times `stat_clr` to land on the edge after the deferral began, and separately on the edge that registers the final counting strobe. In both cases it expects the set bit to survive the clear. A later clear with no set event pending must then return the field to zero.

// File: rtl/defer_wd_pkg.sv
package defer_wd_pkg;

    typedef enum logic [2:0] {
        WD_IDLE,
        WD_DEFER,
        WD_CLEAR,
        WD_ABORT,
        WD_HOLD
    } wd_state_e;

    localparam int unsigned ST_W       = 3;
    localparam int unsigned ST_DEF_BIT = 0;
    localparam int unsigned ST_XD_BIT  = 2;

endpackage

// File: rtl/defer_wd_count.sv
module defer_wd_count #(
    parameter int unsigned NORM_LIMIT = 24288,
    parameter int unsigned LONG_LIMIT = 155680,
    parameter int unsigned CNT_W      = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic fast_mode,
    output logic reach
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim = fast_mode ? CNT_W'(LONG_LIMIT) : CNT_W'(NORM_LIMIT);

    // the strobe being registered now is the one that makes the count hit the limit
    assign reach = adv && ((cnt + CNT_W'(1)) >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv && (cnt < lim)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/defer_wd_fsm.sv
module defer_wd_fsm
    import defer_wd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic carrier,
    input  logic bit_tick,
    input  logic half_duplex,
    input  logic defer_chk_en,
    input  logic reach,
    output logic cnt_clr,
    output logic cnt_adv,
    output logic abort_o,
    output logic defer_o,
    output logic set_xd
);

    wd_state_e state;
    wd_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WD_IDLE: begin
                if (tx_req) nxt = WD_DEFER;
            end
            WD_DEFER: begin
                if (!tx_req)
                    nxt = WD_IDLE;
                else if (!carrier)
                    nxt = WD_CLEAR;
                else if (reach && defer_chk_en && half_duplex)
                    nxt = WD_ABORT;
            end
            WD_CLEAR: begin
                if (!tx_req) nxt = WD_IDLE;
            end
            WD_ABORT: begin
                nxt = tx_req ? WD_HOLD : WD_IDLE;
            end
            WD_HOLD: begin
                if (!tx_req) nxt = WD_IDLE;
            end
            default: nxt = WD_IDLE;
        endcase
    end

    always_comb begin
        cnt_clr = (state == WD_IDLE);
        cnt_adv = (state == WD_DEFER) && tx_req && carrier && bit_tick;
        defer_o = (state == WD_DEFER) && tx_req && carrier && half_duplex;
        abort_o = (state == WD_ABORT);
        set_xd  = (state == WD_DEFER) && (nxt == WD_ABORT);
    end

endmodule

// File: rtl/defer_wd_stat.sv
module defer_wd_stat
    import defer_wd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            set_def,
    input  logic            set_xd,
    output logic [ST_W-1:0] field
);

    logic [ST_W-1:0] set_vec;

    for (genvar g = 0; g < ST_W; g++) begin : g_bit
        if (g == ST_DEF_BIT) begin : g_def
            assign set_vec[g] = set_def;
        end else if (g == ST_XD_BIT) begin : g_xd
            assign set_vec[g] = set_xd;
        end else begin : g_rsv
            assign set_vec[g] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field <= '0;
        end else begin
            field <= (clr ? '0 : field) | set_vec;
        end
    end

endmodule

// File: rtl/defer_watchdog.sv
module defer_watchdog
    import defer_wd_pkg::*;
#(
    parameter int unsigned NORM_LIMIT = 24288,
    parameter int unsigned LONG_LIMIT = 155680
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            carrier,
    input  logic            tx_req,
    input  logic            fast_mode,
    input  logic            defer_chk_en,
    input  logic            half_duplex,
    input  logic            stat_clr,
    output logic            defer_flag,
    output logic            xdef_abort,
    output logic [ST_W-1:0] st_field
);

    localparam int unsigned MAX_LIM = (LONG_LIMIT > NORM_LIMIT) ? LONG_LIMIT : NORM_LIMIT;
    localparam int unsigned CNT_W   = $clog2(MAX_LIM + 2);

    logic cnt_clr;
    logic cnt_adv;
    logic reach;
    logic set_xd;

    defer_wd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_req       (tx_req),
        .carrier      (carrier),
        .bit_tick     (bit_tick),
        .half_duplex  (half_duplex),
        .defer_chk_en (defer_chk_en),
        .reach        (reach),
        .cnt_clr      (cnt_clr),
        .cnt_adv      (cnt_adv),
        .abort_o      (xdef_abort),
        .defer_o      (defer_flag),
        .set_xd       (set_xd)
    );

    defer_wd_count #(
        .NORM_LIMIT (NORM_LIMIT),
        .LONG_LIMIT (LONG_LIMIT),
        .CNT_W      (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .adv       (cnt_adv),
        .fast_mode (fast_mode),
        .reach     (reach)
    );

    defer_wd_stat u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stat_clr),
        .set_def (defer_flag),
        .set_xd  (set_xd),
        .field   (st_field)
    );

endmodule

// File: rtl/defer_watchdog_chk.sv
module defer_watchdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       carrier,
    input logic       tx_req,
    input logic       defer_chk_en,
    input logic       half_duplex,
    input logic       stat_clr,
    input logic       defer_flag,
    input logic       xdef_abort,
    input logic [2:0] st_field
);

    p_abort_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xdef_abort |=> !xdef_abort);

    p_abort_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xdef_abort |-> $past(tx_req && carrier && bit_tick));

    p_abort_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xdef_abort |-> $past(defer_chk_en && half_duplex));

    p_fd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !half_duplex |-> !defer_flag);

    p_withdraw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !xdef_abort);

    p_xd_with_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xdef_abort |-> st_field[2]);

    p_def_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_field[0] && !stat_clr) |=> st_field[0]);

    p_xd_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_field[2] && !stat_clr) |=> st_field[2]);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !defer_flag) |=> !st_field[0]);

endmodule

bind defer_watchdog defer_watchdog_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .carrier      (carrier),
    .tx_req       (tx_req),
    .defer_chk_en (defer_chk_en),
    .half_duplex  (half_duplex),
    .stat_clr     (stat_clr),
    .defer_flag   (defer_flag),
    .xdef_abort   (xdef_abort),
    .st_field     (st_field)
);

// File: tb/defer_watchdog_test.sv
`timescale 1ns/1ps
module defer_watchdog_test;

    localparam int unsigned LN = 12;
    localparam int unsigned LL = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       carrier = 1'b0;
    logic       tx_req = 1'b0;
    logic       fast_mode = 1'b0;
    logic       defer_chk_en = 1'b1;
    logic       half_duplex = 1'b1;
    logic       stat_clr = 1'b0;
    logic       defer_flag;
    logic       xdef_abort;
    logic [2:0] st_field;

    int unsigned cyc = 0;
    int checks = 0;
    int failures = 0;
    int unsigned exp_q[$];
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    defer_watchdog #(.NORM_LIMIT(LN), .LONG_LIMIT(LL)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .carrier      (carrier),
        .tx_req       (tx_req),
        .fast_mode    (fast_mode),
        .defer_chk_en (defer_chk_en),
        .half_duplex  (half_duplex),
        .stat_clr     (stat_clr),
        .defer_flag   (defer_flag),
        .xdef_abort   (xdef_abort),
        .st_field     (st_field)
    );

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side of the scoreboard: expected abort cycle for a request raised now
    task automatic start_req(input int unsigned lim, input bit expect_abort);
        tx_req  = 1'b1;
        carrier = 1'b1;
        if (expect_abort) exp_q.push_back(cyc + 1 + lim);
    endtask

    task automatic end_req_and_clear();
        tx_req   = 1'b0;
        carrier  = 1'b0;
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        @(negedge clk);
    endtask

    // monitor side: every abort pulse must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && xdef_abort && !done) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R3/R8 unexpected abort actual=%0d expected=none", cyc);
            end else begin
                check("R3 abort cycle", cyc, exp_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == 20000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 status", st_field, 0);
        check("R1 abort", xdef_abort, 0);
        check("R1 defer_flag", defer_flag, 0);

        // R3: normal limit abort; R9 field layout
        bit_tick = 1'b1;
        start_req(LN, 1'b1);
        wait_n(LN + 6);
        check("R9 status 101", st_field, 3'b101);
        // R8: hold with request high, no second abort
        wait_n(25);
        check("R8 held flag", defer_flag, 0);
        end_req_and_clear();
        check("R10 cleared", st_field, 0);

        // R4: long limit
        fast_mode = 1'b1;
        start_req(LL, 1'b1);
        wait_n(LL + 6);
        check("R4 xd bit", st_field[2], 1);
        end_req_and_clear();
        fast_mode = 1'b0;

        // R2: no strobe, no count
        bit_tick = 1'b0;
        start_req(LN, 1'b0);
        wait_n(40);
        check("R11 defer_flag", defer_flag, 1);
        check("R2 no count status", st_field, 3'b001);
        bit_tick = 1'b1;
        exp_q.push_back(cyc + LN);
        wait_n(LN + 5);
        check("R2 resumed abort status", st_field, 3'b101);
        end_req_and_clear();

        // R7: carrier drop freezes and ends deferral
        start_req(LN, 1'b0);
        wait_n(8);
        carrier = 1'b0;
        wait_n(30);
        check("R7 flag after drop", defer_flag, 0);
        carrier = 1'b1;
        wait_n(30);
        check("R7 status", st_field, 3'b001);
        end_req_and_clear();

        // R5: check disabled
        defer_chk_en = 1'b0;
        start_req(LN, 1'b0);
        wait_n(50);
        check("R5 status", st_field, 3'b001);
        check("R5 still deferring", defer_flag, 1);
        end_req_and_clear();
        defer_chk_en = 1'b1;

        // R6: full-duplex
        half_duplex = 1'b0;
        start_req(LN, 1'b0);
        wait_n(50);
        check("R6 status", st_field, 0);
        check("R6 flag", defer_flag, 0);
        end_req_and_clear();
        half_duplex = 1'b1;

        // R8: early withdraw, then R2 restart from zero
        start_req(LN, 1'b0);
        wait_n(LN - 3);
        tx_req = 1'b0;
        wait_n(3);
        start_req(LN, 1'b1);
        wait_n(LN + 6);
        check("R8 restart status", st_field, 3'b101);
        end_req_and_clear();

        // R10: clear during deferral, set wins
        start_req(LN, 1'b0);
        wait_n(4);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        check("R10 set wins def", st_field[0], 1);
        carrier = 1'b0;
        wait_n(2);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        check("R10 clear after drop", st_field, 0);
        end_req_and_clear();

        // R10: clear at the abort edge, set wins
        start_req(LN, 1'b1);
        wait_n(LN);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        check("R10 set wins xd", st_field[2], 1);
        check("R10 abort seen", xdef_abort, 1);
        end_req_and_clear();
        check("R10 final clear", st_field, 0);

        wait_n(5);
        done = 1'b1;
        check("R3 all aborts seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule